// File: doc/BRIEF.md
# VGA Character Cell Display

This block drives a VGA monitor with a text status screen. It runs its own horizontal and vertical pixel counters and produces active-low sync pulses. It emits one bit each of red, green and blue for every pixel. The visible area is a grid of 8x8-pixel character cells. The cell column and row come straight from the upper bits of the counters. The low three bits of each counter pick the pixel inside the glyph.

A fixed screen map places glyphs in cells. It holds a solid marker block in the top-left cell, a second marker in the green band, a five-letter label, and a row of digit cells whose glyphs follow the `digit_val` input. A horizontal bar graph of length `bar_len` is drawn in blue over a band of rows, starting just right of a fixed axis column. Glyph bitmaps are built into the logic as constants, eight 8-bit rows per glyph.

Screen lookup takes two register stages. The sync outputs are delayed by the same two stages, so sync and colour for any pixel leave the block together. The digit and bar inputs are captured once per frame, so a frame is never drawn from mixed values. All timing and layout positions are parameters. The defaults give 640x480 from a 25 MHz pixel clock.

Top module: `vga_text_panel`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks (default 640+16+96+48 = 800). A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines (default 480+10+2+33 = 525). `hsync_n` is low for pixels with H_ACTIVE+H_FP <= x < H_ACTIVE+H_FP+H_SYNC. `vsync_n` is low for lines with V_ACTIVE+V_FP <= y < V_ACTIVE+V_FP+V_SYNC. The sync and colour outputs for pixel (x,y) appear together, on the second clock edge after the counters hold (x,y).
- R2: For any pixel outside the active area, red, green and blue are all 0.
- R3: A pixel (x,y) belongs to cell column x>>3 and cell row y>>3. Its glyph row is y[2:0] and its glyph column is x[2:0]. Glyph column 0 is the most significant bit of the 8-bit row vector.
- R4: A pixel whose glyph bit is 0 is drawn white (red=green=blue=1).
- R5: A lit glyph pixel is red (1,0,0) in cell rows 0 to 3 and green (0,1,0) in cell rows 8 to 11. Everywhere else it is black (0,0,0). The solid glyph, with every pixel lit, sits at cells (0,0) and (2,9).
- R6: Digit i (i = 0 to NUM_DIGITS-1) comes from `digit_val[4i+3:4i]` and is shown in cell row DIGIT_ROW (default 6), cell column DIGIT_COL+i (default 10+i). Codes 10 to 15 show the blank glyph. Cells holding the same code render identically. Row 0 of the glyph for 1 lights exactly glyph columns 3 and 4. Row 0 of the glyph for 0 and for 8 lights glyph columns 2 to 5.
- R7: On lines BAR_Y0 <= y < BAR_Y0+BAR_ROWS (default 96 to 111), a pixel is blue (0,0,1) when BAR_AXIS < x < BAR_AXIS+length (default axis 80). A length of 0 draws nothing.
- R8: `digit_val` and `bar_len` are sampled only at the clock edge where the counters hold x=0, y=V_ACTIVE. Any change at another time first shows in the next frame. Reset clears both captured values to 0.
- R9: While `rst` is high, both syncs are high and all colours are 0. After release the counters start at (0,0). Pixel (0,0) appears on the second edge, and the first edge still gives the reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| digit_val | input | 4*NUM_DIGITS | Packed 4-bit digit codes, digit 0 in the low nibble |
| bar_len | input | BAR_W | Bar graph length in pixels |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 1 | Red gun |
| green | output | 1 | Green gun |
| blue | output | 1 | Blue gun |

## Verification
The bench shrinks the porches and active area through the parameters, so several whole frames fit in the run. It probes pixels at cell edges and just across them, which separates correct counter slicing from off-by-one cell decoding and confirms the pipeline alignment. Colour is sampled in the red band, the green band and the default area, which tells the region colouring apart from the white background. The bar is probed at both ends of its range, at the rows just outside its band, and at zero length. Digit cells are loaded with a repeated code, a blank code and the code 1. Inputs are changed in mid-frame, which shows whether the design samples them once per frame or passes them straight through.

// File: rtl/vga_text_panel.sv
module vga_text_panel #(
  parameter int H_ACTIVE   = 640,
  parameter int H_FP       = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BP       = 48,
  parameter int V_ACTIVE   = 480,
  parameter int V_FP       = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BP       = 33,
  parameter int NUM_DIGITS = 4,
  parameter int DIGIT_COL  = 10,
  parameter int DIGIT_ROW  = 6,
  parameter int LABEL_COL  = 3,
  parameter int RED_ROWS   = 4,
  parameter int GREEN_ROW0 = 8,
  parameter int GREEN_ROWS = 4,
  parameter int BAR_Y0     = 96,
  parameter int BAR_ROWS   = 16,
  parameter int BAR_AXIS   = 80,
  parameter int BAR_W      = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4*NUM_DIGITS-1:0] digit_val,
  input  logic [BAR_W-1:0]        bar_len,
  output logic                    hsync_n,
  output logic                    vsync_n,
  output logic                    red,
  output logic                    green,
  output logic                    blue
);

  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);
  localparam int HS_LO   = H_ACTIVE + H_FP;
  localparam int HS_HI   = HS_LO + H_SYNC;
  localparam int VS_LO   = V_ACTIVE + V_FP;
  localparam int VS_HI   = VS_LO + V_SYNC;

  localparam logic [4:0] G_BLANK = 5'd10;
  localparam logic [4:0] G_SOLID = 5'd11;
  localparam logic [4:0] G_F     = 5'd12;
  localparam logic [4:0] G_I     = 5'd13;
  localparam logic [4:0] G_E     = 5'd14;
  localparam logic [4:0] G_L     = 5'd15;
  localparam logic [4:0] G_D     = 5'd16;

  localparam logic [2:0] C_WHITE = 3'b111;
  localparam logic [2:0] C_BLACK = 3'b000;
  localparam logic [2:0] C_RED   = 3'b100;
  localparam logic [2:0] C_GREEN = 3'b010;
  localparam logic [2:0] C_BLUE  = 3'b001;

  function automatic logic [7:0] glyph_row(input logic [4:0] g, input logic [2:0] r);
    logic [63:0] bm;
    case (g)
      5'd0:    bm = 64'h3C666E7666663C00;
      5'd1:    bm = 64'h183818181818_7E00;
      5'd2:    bm = 64'h3C66060C30607E00;
      5'd3:    bm = 64'h3C66061C06663C00;
      5'd4:    bm = 64'h0C1C3C6C7E0C0C00;
      5'd5:    bm = 64'h7E607C0606663C00;
      5'd6:    bm = 64'h1C30607C66663C00;
      5'd7:    bm = 64'h7E060C1830303000;
      5'd8:    bm = 64'h3C66663C66663C00;
      5'd9:    bm = 64'h3C66663E060C3800;
      G_SOLID: bm = 64'hFFFFFFFFFFFFFFFF;
      G_F:     bm = 64'h7E60607C60606000;
      G_I:     bm = 64'h3C18181818183C00;
      G_E:     bm = 64'h7E60607C60607E00;
      G_L:     bm = 64'h6060606060607E00;
      G_D:     bm = 64'h786C6666666C7800;
      default: bm = 64'h0;
    endcase
    return bm[8*(7-int'(r)) +: 8];
  endfunction

  logic [HW-1:0] hc;
  logic [VW-1:0] vc;

  always_ff @(posedge clk) begin
    if (rst) begin
      hc <= '0;
      vc <= '0;
    end else if (int'(hc) == H_TOTAL - 1) begin
      hc <= '0;
      vc <= (int'(vc) == V_TOTAL - 1) ? '0 : vc + 1'b1;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  logic                    frame_pt;
  logic [4*NUM_DIGITS-1:0] dig_q;
  logic [BAR_W-1:0]        bar_q;

  assign frame_pt = (hc == '0) && (int'(vc) == V_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      dig_q <= '0;
      bar_q <= '0;
    end else if (frame_pt) begin
      dig_q <= digit_val;
      bar_q <= bar_len;
    end
  end

  logic [HW-4:0] col;
  logic [VW-4:0] row;
  logic [4:0]    gsel;
  logic [2:0]    lit_c;
  logic          act0, bar0, hs0, vs0;

  assign col  = hc[HW-1:3];
  assign row  = vc[VW-1:3];
  assign act0 = (int'(hc) < H_ACTIVE) && (int'(vc) < V_ACTIVE);
  assign hs0  = !((int'(hc) >= HS_LO) && (int'(hc) < HS_HI));
  assign vs0  = !((int'(vc) >= VS_LO) && (int'(vc) < VS_HI));
  assign bar0 = (int'(vc) >= BAR_Y0) && (int'(vc) < BAR_Y0 + BAR_ROWS) &&
                (int'(hc) > BAR_AXIS) && (int'(hc) < BAR_AXIS + int'(bar_q));

  always_comb begin
    gsel = G_BLANK;
    if (row == '0 && col == '0) gsel = G_SOLID;
    if (int'(row) == GREEN_ROW0 + 1 && int'(col) == 2) gsel = G_SOLID;
    if (int'(row) == DIGIT_ROW) begin
      case (int'(col) - LABEL_COL)
        0:       gsel = G_F;
        1:       gsel = G_I;
        2:       gsel = G_E;
        3:       gsel = G_L;
        4:       gsel = G_D;
        default: ;
      endcase
      for (int i = 0; i < NUM_DIGITS; i++) begin
        if (int'(col) == DIGIT_COL + i)
          gsel = (dig_q[4*i +: 4] <= 4'd9) ? {1'b0, dig_q[4*i +: 4]} : G_BLANK;
      end
    end
  end

  always_comb begin
    if (int'(row) < RED_ROWS)
      lit_c = C_RED;
    else if (int'(row) >= GREEN_ROW0 && int'(row) < GREEN_ROW0 + GREEN_ROWS)
      lit_c = C_GREEN;
    else
      lit_c = C_BLACK;
  end

  logic [4:0] g1;
  logic [2:0] gx1, gy1, lit1;
  logic       act1, bar1, hs1, vs1;

  always_ff @(posedge clk) begin
    if (rst) begin
      g1   <= G_BLANK;
      gx1  <= '0;
      gy1  <= '0;
      lit1 <= C_BLACK;
      act1 <= 1'b0;
      bar1 <= 1'b0;
      hs1  <= 1'b1;
      vs1  <= 1'b1;
    end else begin
      g1   <= gsel;
      gx1  <= hc[2:0];
      gy1  <= vc[2:0];
      lit1 <= lit_c;
      act1 <= act0;
      bar1 <= bar0;
      hs1  <= hs0;
      vs1  <= vs0;
    end
  end

  logic [7:0] rbits;
  logic       pix_on;
  logic [2:0] colour;

  assign rbits  = glyph_row(g1, gy1);
  assign pix_on = rbits[3'd7 - gx1];

  always_comb begin
    if (!act1)      colour = C_BLACK;
    else if (bar1)  colour = C_BLUE;
    else if (pix_on) colour = lit1;
    else            colour = C_WHITE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {red, green, blue} <= 3'b000;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      {red, green, blue} <= colour;
      hsync_n <= hs1;
      vsync_n <= vs1;
    end
  end

  p_line_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (int'(hc) == H_TOTAL - 1) |=> (hc == '0));

  p_hsync_align_r1: assert property (@(posedge clk) disable iff (rst)
    hsync_n == !((int'($past(hc, 2)) >= HS_LO) && (int'($past(hc, 2)) < HS_HI)));

  p_vsync_align_r1: assert property (@(posedge clk) disable iff (rst)
    vsync_n == !((int'($past(vc, 2)) >= VS_LO) && (int'($past(vc, 2)) < VS_HI)));

  p_blank_dark_r2: assert property (@(posedge clk) disable iff (rst)
    !((int'($past(hc, 2)) < H_ACTIVE) && (int'($past(vc, 2)) < V_ACTIVE))
      |-> ({red, green, blue} == 3'b000));

  p_frame_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_pt |=> ($stable(dig_q) && $stable(bar_q)));

endmodule

// File: tb/tb_vga_text_panel.sv
module tb_vga_text_panel;
  localparam int CLK_PERIOD = 10;
  localparam int HA = 160, HF = 8, HS = 16, HB = 8;
  localparam int VA = 120, VF = 2, VS = 2, VB = 4;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FRAME = HT * VT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] digit_val = '0;
  logic [9:0]  bar_len = '0;
  logic        hsync_n, vsync_n, red, green, blue;

  vga_text_panel #(
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) dut (
    .clk(clk), .rst(rst), .digit_val(digit_val), .bar_len(bar_len),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .red(red), .green(green), .blue(blue)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input string what, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic goto(input int f, input int x, input int y);
    int tgt;
    tgt = f * FRAME + y * HT + x;
    @(negedge clk);
    while (cyc - 2 != tgt) @(negedge clk);
  endtask

  task automatic pix(input string req, input int f, input int x, input int y, input logic [2:0] exp);
    goto(f, x, y);
    chk(req, $sformatf("pixel(%0d,%0d) f%0d", x, y, f), {red, green, blue}, exp);
  endtask

  task automatic t_reset();
    digit_val = 16'h7C71;
    bar_len   = 10'd20;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9", "reset sync", {1'b0, hsync_n, vsync_n}, 3'b011);
    chk("R9", "reset rgb", {red, green, blue}, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "first edge rgb", {red, green, blue}, 3'b000);
    chk("R9", "first edge hsync", {2'b0, hsync_n}, 3'b001);
    @(negedge clk);
    chk("R9", "pixel(0,0) at second edge", {red, green, blue}, 3'b100);
  endtask

  task automatic t_marker();
    pix("R3", 0, 8, 0, 3'b111);
    pix("R5", 0, 3, 4, 3'b100);
    pix("R3", 0, 7, 7, 3'b100);
    pix("R4", 0, 0, 8, 3'b111);
  endtask

  task automatic t_hsync();
    goto(0, 167, 20); chk("R1", "hsync x=167", {2'b0, hsync_n}, 3'b001);
    goto(0, 168, 20); chk("R1", "hsync x=168", {2'b0, hsync_n}, 3'b000);
    goto(0, 183, 20); chk("R1", "hsync x=183", {2'b0, hsync_n}, 3'b000);
    goto(0, 184, 20); chk("R1", "hsync x=184", {2'b0, hsync_n}, 3'b001);
    pix("R2", 0, 170, 30, 3'b000);
  endtask

  task automatic t_region();
    pix("R8", 0, 82, 48, 3'b000);
    pix("R5", 0, 16, 72, 3'b010);
    pix("R5", 0, 24, 72, 3'b111);
    pix("R5", 0, 23, 79, 3'b010);
    pix("R8", 0, 81, 100, 3'b111);
  endtask

  task automatic t_vsync();
    goto(0, 0, 121); chk("R1", "vsync y=121", {2'b0, vsync_n}, 3'b001);
    goto(0, 0, 122); chk("R1", "vsync y=122", {2'b0, vsync_n}, 3'b000);
    goto(0, 0, 123); chk("R1", "vsync y=123", {2'b0, vsync_n}, 3'b000);
    goto(0, 0, 124); chk("R1", "vsync y=124", {2'b0, vsync_n}, 3'b001);
    pix("R2", 0, 10, 125, 3'b000);
  endtask

  task automatic t_digits();
    logic [2:0] cap [8][32];
    logic       blank_ok, same_ok;
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 32; x++) begin
        goto(1, 80 + x, 48 + y);
        cap[y][x] = {red, green, blue};
      end
    for (int x = 0; x < 8; x++)
      chk("R6", $sformatf("digit 1 row0 col%0d", x), cap[0][x],
          (x == 3 || x == 4) ? 3'b000 : 3'b111);
    blank_ok = 1'b1;
    same_ok  = 1'b1;
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++) begin
        if (cap[y][16 + x] !== 3'b111) blank_ok = 1'b0;
        if (cap[y][8 + x] !== cap[y][24 + x]) same_ok = 1'b0;
      end
    chk("R6", "code 12 cell all white", {2'b0, blank_ok}, 3'b001);
    chk("R6", "equal codes render alike", {2'b0, same_ok}, 3'b001);
  endtask

  task automatic t_bar_mid_frame();
    goto(1, 0, 60);
    bar_len   = 10'd40;
    digit_val = 16'h0008;
    pix("R7", 1, 90, 95, 3'b111);
    pix("R7", 1, 80, 100, 3'b111);
    pix("R7", 1, 81, 100, 3'b001);
    pix("R7", 1, 99, 100, 3'b001);
    pix("R7", 1, 100, 100, 3'b111);
    pix("R8", 1, 110, 100, 3'b111);
    pix("R7", 1, 90, 112, 3'b111);
  endtask

  task automatic t_next_frame();
    pix("R8", 2, 81, 48, 3'b111);
    pix("R6", 2, 82, 48, 3'b000);
    pix("R8", 2, 110, 100, 3'b001);
    pix("R7", 2, 119, 100, 3'b001);
    pix("R7", 2, 120, 100, 3'b111);
    goto(2, 0, 112);
    bar_len = 10'd0;
    pix("R7", 3, 81, 100, 3'b111);
    pix("R7", 3, 90, 104, 3'b111);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_marker();
    t_hsync();
    t_region();
    t_vsync();
    t_digits();
    t_bar_mid_frame();
    t_next_frame();
    summary();
    $finish;
  end
endmodule